// File: doc/BRIEF.md
# Refill Data Grace-Wait and Replay Controller

This block is the second-stage control of a cache pipeline for refill requests. A miss-handling entry may launch its refill into the pipeline on an early hint, before the refill data is forwarded. When the request reaches this stage it looks for forwarded data tagged with its own miss-entry identifier. If the data is there, the request moves on to the final stage. That stage presents a combined result: the refill data to write, a refill-complete response for the owning entry, and a writeback request for the victim line when that line holds any valid state.

If the data is missing, the request may wait in place for a bounded grace period, one cycle by default. While it waits, upstream stages are held and the final stage receives a bubble. If the data still has not arrived when the grace period ends, the request is dropped. In that cycle a replay is signalled, carrying the entry identifier, so the owning entry resends its refill. A request whose victim line is marked busy in another pending miss entry is dropped and replayed at once.

The upstream and result interfaces are valid/ready. The upstream side takes a request only when `in_valid` and `in_ready` are both high; `in_ready` goes low whenever the stage is stalled. The result side holds `res_valid` and every `res_*` field steady until `res_ready` is seen. A full result slot back-pressures the stage. Data captured before that back-pressure stays safe and is never replayed. `stall`, `kill` and the replay pins are plain control outputs.

Top module: `refill_replay_ctrl`

## Requirements
- R1: During and straight after reset, `res_valid`, `stall`, `kill` and `replay_valid` are low and `in_ready` is high.
- R2: A request whose forwarded data (`fwd_valid` with `fwd_id` equal to its entry id) is present in its first stage cycle does not stall. It appears on `res_valid` in the next cycle with that data and its entry id.
- R3: A request with no matching forwarded data in its first stage cycle raises `stall` and drops `in_ready` for that cycle.
- R4: When matching data is still absent after the grace period (one cycle by default), `kill` and `replay_valid` assert with `replay_id` equal to the request's entry id, and the request yields no result.
- R5: A request taken with `in_victim_busy` high is killed and replayed in its first stage cycle, whether or not data is forwarded.
- R6: Forwarded data whose `fwd_id` differs from the request's entry id is ignored and counts as absent.
- R7: `res_wb` is 1 exactly when the victim state is not invalid (state encoding 00 invalid, 01 shared, 10 exclusive, 11 dirty), and `res_wb_addr` carries the victim address.
- R8: While `res_valid` is high and `res_ready` low, the result and its fields hold. A request that has captured its data waits behind the full slot with `stall` high, for any number of cycles, without replay.
- R9: While the stage stalls, no new item enters the result slot, so an empty slot keeps `res_valid` low.
- R10: `kill` and `replay_valid` last one cycle, coincide, and free the stage: `in_ready` is high and `stall` low in that cycle, so a new request can be taken then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Refill request offered from stage 1 |
| in_ready | output | 1 | Stage can take a request this cycle |
| in_id | input | ID_W | Owning miss-entry identifier |
| in_victim_state | input | 2 | Coherence state of the victim line |
| in_victim_addr | input | ADDR_W | Victim line address |
| in_victim_busy | input | 1 | Victim line is held by another pending miss entry |
| fwd_valid | input | 1 | Forwarded refill data present this cycle |
| fwd_id | input | ID_W | Entry that owns the forwarded data |
| fwd_data | input | DATA_W | Forwarded refill data |
| stall | output | 1 | Stage holds; upstream stages must hold |
| replay_valid | output | 1 | Replay request to the owning miss entry |
| replay_id | output | ID_W | Entry that must resend its refill |
| kill | output | 1 | Current request leaves the pipeline without data operations |
| res_valid | output | 1 | Final-stage result present |
| res_ready | input | 1 | Consumer takes the result |
| res_id | output | ID_W | Entry for the refill-complete response |
| res_data | output | DATA_W | Refill data to write into the arrays |
| res_wb | output | 1 | Victim writeback request needed |
| res_wb_addr | output | ADDR_W | Victim address for the writeback |

## Verification
Requests are tried with forwarded data that arrives on time, one cycle late, never, and only under a foreign entry id. These cases separate the pass-through path, the grace wait, the timeout replay and the identifier match. A busy victim with data already present shows that the busy check comes before the data check. Holding `res_ready` low while a second request captures its data, and keeping it low well past the grace period, shows that back-pressure stalls are not mistaken for missing data. A fresh request taken in the very cycle of a kill shows that the slot is released at once. Victim states of invalid, shared and dirty tell apart when a writeback is requested.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    LINE_INVALID = 2'b00,
    LINE_SHARED  = 2'b01,
    LINE_EXCL    = 2'b10,
    LINE_DIRTY   = 2'b11
  } line_state_e;

  typedef enum logic [2:0] {
    S2_IDLE,
    S2_WAIT,
    S2_HOLD,
    S2_ADVANCE,
    S2_DROP
  } s2_act_e;

endpackage

// File: rtl/refill_grace_timer.sv
module refill_grace_timer #(
  parameter int GRACE = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clear,
  output logic expired
);
  localparam int CW = (GRACE < 1) ? 1 : $clog2(GRACE + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(GRACE));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clear)
      cnt <= '0;
    else if (arm && !expired)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/refill_s2_decide.sv
module refill_s2_decide
  import refill_pkg::*;
(
  input  logic    occupied,
  input  logic    victim_busy,
  input  logic    data_ready,
  input  logic    grace_over,
  input  logic    next_free,
  output s2_act_e act
);
  always_comb begin
    if (!occupied)
      act = S2_IDLE;
    else if (victim_busy)
      act = S2_DROP;
    else if (data_ready)
      act = next_free ? S2_ADVANCE : S2_HOLD;
    else if (grace_over)
      act = S2_DROP;
    else
      act = S2_WAIT;
  end
endmodule

// File: rtl/refill_slot.sv
module refill_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full;
  logic [W-1:0] held;

  assign in_ready  = !full || out_ready;
  assign out_valid = full;
  assign out_data  = held;

  always_ff @(posedge clk) begin
    if (!rst_n)
      full <= 1'b0;
    else if (in_ready)
      full <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready)
      held <= in_data;
  end
endmodule

// File: rtl/refill_replay_ctrl.sv
module refill_replay_ctrl
  import refill_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int GRACE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [1:0]        in_victim_state,
  input  logic [ADDR_W-1:0] in_victim_addr,
  input  logic              in_victim_busy,
  input  logic              fwd_valid,
  input  logic [ID_W-1:0]   fwd_id,
  input  logic [DATA_W-1:0] fwd_data,
  output logic              stall,
  output logic              replay_valid,
  output logic [ID_W-1:0]   replay_id,
  output logic              kill,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ID_W-1:0]   res_id,
  output logic [DATA_W-1:0] res_data,
  output logic              res_wb,
  output logic [ADDR_W-1:0] res_wb_addr
);
  localparam int PW = ID_W + DATA_W + 1 + ADDR_W;

  // stage-2 holding state
  logic              s2_vld;
  logic              s2_have;
  logic [ID_W-1:0]   s2_id;
  line_state_e       s2_state;
  logic [ADDR_W-1:0] s2_addr;
  logic              s2_busy;
  logic [DATA_W-1:0] s2_data;

  logic    fwd_hit;
  logic    grace_over;
  logic    next_free;
  logic    leave;
  s2_act_e act;

  logic [DATA_W-1:0] pass_data;
  logic [PW-1:0]     s3_in;
  logic [PW-1:0]     s3_out;

  assign fwd_hit = s2_vld && fwd_valid && (fwd_id == s2_id);

  refill_s2_decide u_decide (
    .occupied    (s2_vld),
    .victim_busy (s2_busy),
    .data_ready  (s2_have || fwd_hit),
    .grace_over  (grace_over),
    .next_free   (next_free),
    .act         (act)
  );

  assign leave        = (act == S2_ADVANCE) || (act == S2_DROP);
  assign in_ready     = !s2_vld || leave;
  assign stall        = s2_vld && !leave;
  assign kill         = (act == S2_DROP);
  assign replay_valid = kill;
  assign replay_id    = s2_id;

  refill_grace_timer #(.GRACE(GRACE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (act == S2_WAIT),
    .clear   (leave),
    .expired (grace_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_have <= 1'b0;
    end else if (in_ready) begin
      s2_vld  <= in_valid;
      s2_have <= 1'b0;
    end else if (act == S2_HOLD && fwd_hit) begin
      s2_have <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      s2_id    <= in_id;
      s2_state <= line_state_e'(in_victim_state);
      s2_addr  <= in_victim_addr;
      s2_busy  <= in_victim_busy;
    end else if (act == S2_HOLD && fwd_hit && !s2_have) begin
      s2_data  <= fwd_data;
    end
  end

  assign pass_data = s2_have ? s2_data : fwd_data;
  assign s3_in     = {s2_id, pass_data, (s2_state != LINE_INVALID), s2_addr};

  refill_slot #(.W(PW)) u_s3 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (act == S2_ADVANCE),
    .in_ready  (next_free),
    .in_data   (s3_in),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (s3_out)
  );

  assign {res_id, res_data, res_wb, res_wb_addr} = s3_out;
endmodule

// File: rtl/refill_replay_ctrl_chk.sv
module refill_replay_ctrl_chk #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_victim_busy,
  input logic              fwd_valid,
  input logic              stall,
  input logic              kill,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ID_W-1:0]   res_id,
  input logic [DATA_W-1:0] res_data,
  input logic              res_wb,
  input logic [ADDR_W-1:0] res_wb_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !kill && !stall)); // R1

  AST_FIRST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_victim_busy) ##1 !fwd_valid |-> stall); // R3

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_victim_busy) |=> kill); // R5

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_id)
                                    && $stable(res_wb) && $stable(res_wb_addr))); // R8

  AST_KILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (in_ready && !stall)); // R10
endmodule

bind refill_replay_ctrl refill_replay_ctrl_chk #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/refill_replay_ctrl_test.sv
module refill_replay_ctrl_test;
  localparam int ID_W   = 4;
  localparam int ADDR_W = 40;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ID_W-1:0]   in_id = '0;
  logic [1:0]        in_victim_state = '0;
  logic [ADDR_W-1:0] in_victim_addr = '0;
  logic              in_victim_busy = 1'b0;
  logic              fwd_valid = 1'b0;
  logic [ID_W-1:0]   fwd_id = '0;
  logic [DATA_W-1:0] fwd_data = '0;
  logic              stall;
  logic              replay_valid;
  logic [ID_W-1:0]   replay_id;
  logic              kill;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic [ID_W-1:0]   res_id;
  logic [DATA_W-1:0] res_data;
  logic              res_wb;
  logic [ADDR_W-1:0] res_wb_addr;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  refill_replay_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_fwd();
    fwd_valid = 1'b0;
    fwd_id    = '0;
    fwd_data  = '0;
  endtask

  task automatic give_fwd(input logic [ID_W-1:0] id, input logic [DATA_W-1:0] d);
    fwd_valid = 1'b1;
    fwd_id    = id;
    fwd_data  = d;
  endtask

  // Offers one request; returns at the negedge of its first stage-2 cycle.
  task automatic put_req(input logic [ID_W-1:0] id, input logic [1:0] st,
                         input logic [ADDR_W-1:0] a, input logic busy);
    @(negedge clk);
    clear_fwd();
    in_valid = 1'b1; in_id = id; in_victim_state = st;
    in_victim_addr = a; in_victim_busy = busy;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 res_valid", res_valid, 0);
    chk("R1 stall", stall, 0);
    chk("R1 kill", kill, 0);
    chk("R1 replay_valid", replay_valid, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_on_time();
    put_req(4'h3, 2'b11, 40'h12_3456_7800, 1'b0);
    give_fwd(4'h3, 64'hDEAD_BEEF_0000_0001);
    #1;
    chk("R2 no stall", stall, 0);
    chk("R2 no kill", kill, 0);
    @(negedge clk); clear_fwd(); #1;
    chk("R2 res_valid", res_valid, 1);
    chk("R2 res_data", res_data, 64'hDEAD_BEEF_0000_0001);
    chk("R2 res_id", res_id, 4'h3);
    chk("R7 wb dirty", res_wb, 1);
    chk("R7 wb addr", res_wb_addr, 40'h12_3456_7800);
    @(negedge clk); #1;
    chk("R2 drained", res_valid, 0);
  endtask

  task automatic t_late_one();
    put_req(4'h4, 2'b00, 40'h00_0000_1000, 1'b0);
    #1;
    chk("R3 stall", stall, 1);
    chk("R3 in_ready", in_ready, 0);
    chk("R9 bubble", res_valid, 0);
    @(negedge clk); give_fwd(4'h4, 64'h0123_4567_89AB_CDEF); #1;
    chk("R3 released", stall, 0);
    chk("R3 no kill", kill, 0);
    @(negedge clk); clear_fwd(); #1;
    chk("R3 res_valid", res_valid, 1);
    chk("R3 res_data", res_data, 64'h0123_4567_89AB_CDEF);
    chk("R7 no wb invalid", res_wb, 0);
    @(negedge clk);
  endtask

  task automatic t_absent();
    put_req(4'h9, 2'b01, 40'h00_0000_2000, 1'b0);
    #1;
    chk("R4 grace stall", stall, 1);
    chk("R4 no early kill", kill, 0);
    @(negedge clk);
    in_valid = 1'b1; in_id = 4'h2; in_victim_state = 2'b01;
    in_victim_addr = 40'h00_0000_3000; in_victim_busy = 1'b0;
    #1;
    chk("R4 kill", kill, 1);
    chk("R4 replay_valid", replay_valid, 1);
    chk("R4 replay_id", replay_id, 4'h9);
    chk("R10 in_ready on kill", in_ready, 1);
    chk("R10 no stall on kill", stall, 0);
    @(negedge clk);
    in_valid = 1'b0;
    give_fwd(4'h2, 64'h5555_AAAA_5555_AAAA);
    #1;
    chk("R10 kill one cycle", kill, 0);
    chk("R10 replay one cycle", replay_valid, 0);
    chk("R4 no result", res_valid, 0);
    chk("R10 new req flows", stall, 0);
    @(negedge clk); clear_fwd(); #1;
    chk("R10 new res_id", res_id, 4'h2);
    chk("R10 new res_data", res_data, 64'h5555_AAAA_5555_AAAA);
    chk("R7 wb shared", res_wb, 1);
    @(negedge clk);
  endtask

  task automatic t_wrong_id();
    put_req(4'h5, 2'b10, 40'h00_0000_4000, 1'b0);
    give_fwd(4'h6, 64'h1111_2222_3333_4444);
    #1;
    chk("R6 foreign data stalls", stall, 1);
    @(negedge clk); #1;
    chk("R6 foreign data kill", kill, 1);
    chk("R6 replay_id", replay_id, 4'h5);
    @(negedge clk); clear_fwd(); #1;
    chk("R6 no result", res_valid, 0);
  endtask

  task automatic t_busy();
    put_req(4'h7, 2'b11, 40'h00_0000_5000, 1'b1);
    give_fwd(4'h7, 64'h7777_7777_7777_7777);
    #1;
    chk("R5 kill", kill, 1);
    chk("R5 replay_valid", replay_valid, 1);
    chk("R5 replay_id", replay_id, 4'h7);
    chk("R5 no stall", stall, 0);
    @(negedge clk); clear_fwd(); #1;
    chk("R5 kill one cycle", kill, 0);
    chk("R5 no result", res_valid, 0);
  endtask

  task automatic t_backpressure();
    res_ready = 1'b0;
    put_req(4'hA, 2'b01, 40'h00_0000_6000, 1'b0);
    give_fwd(4'hA, 64'hAAAA_0000_0000_000A);
    put_req(4'hB, 2'b00, 40'h00_0000_7000, 1'b0);
    give_fwd(4'hB, 64'hBBBB_0000_0000_000B);
    #1;
    chk("R8 slot full", res_valid, 1);
    chk("R8 held data A", res_data, 64'hAAAA_0000_0000_000A);
    chk("R8 stall behind slot", stall, 1);
    chk("R8 no kill", kill, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); clear_fwd(); #1;
      chk("R8 still stalled", stall, 1);
      chk("R8 no replay", replay_valid, 0);
      chk("R8 held id A", res_id, 4'hA);
    end
    res_ready = 1'b1;
    #1;
    chk("R8 A offered", res_data, 64'hAAAA_0000_0000_000A);
    @(negedge clk); #1;
    chk("R8 B follows", res_valid, 1);
    chk("R8 B data", res_data, 64'hBBBB_0000_0000_000B);
    chk("R8 B id", res_id, 4'hB);
    @(negedge clk); #1;
    chk("R8 drained", res_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 after reset", res_valid, 0);
    t_on_time();
    t_late_one();
    t_absent();
    t_wrong_id();
    t_busy();
    t_backpressure();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule